// File: doc/BRIEF.md
# Privilege Stack Pointer Fetch Unit

This unit looks up the stack for an inner privilege level in the task-state segment of the running task. A privilege transition hands it a target level, the descriptor type of the task register (busy 32-bit or busy 16-bit task), the segment base and limit, and the task register selector. The unit works out where the stack pair for that level sits inside the segment and checks that the pair fits within the limit. It then fetches the stack pointer and the stack selector through a request/acknowledge memory port. The result is either a one-cycle done pulse with the new selector and pointer, or a one-cycle fault pulse with a fault kind and an error code.

A second mode reads the back-link selector, which is the word at offset 0 of the segment. The same fault handling applies to it. The unit does not parse descriptors and does not perform the task switch; it only supplies the values a switch or an inter-level call needs.

All checks are done from registered copies of the request, one cycle before any memory traffic. A request that faults therefore never touches memory.

Top module: `ring_stack_fetch`

## Requirements
- R1: For a busy 32-bit task (descriptor type 4'hB), the entry offset is level*8+4. The pointer is a dword read at base+offset, and the selector is a word read at base+offset+4.
- R2: For a busy 16-bit task (descriptor type 4'h3), the entry offset is level*4+2. The pointer is a word read at base+offset, zero-extended to 32 bits (upper 16 bits of `stack_ptr_o` are 0). The selector is a word read at base+offset+2.
- R3: For a 32-bit task, a stack lookup with offset+7 > limit faults with `fault_kind_o`=1 (task-segment fault). `fault_code_o` equals the task selector with bits 1:0 cleared.
- R4: For a 16-bit task, a stack lookup with offset+3 > limit faults the same way, with kind 1 and the selector with bits 1:0 cleared.
- R5: Any descriptor type other than 4'hB or 4'h3 faults with kind 2 and `fault_code_o`=0, in both modes. This check has priority over all others.
- R6: In stack mode, a level of 3 faults with kind 3 and code 0. This check has priority over the limit check.
- R7: Back-link mode (`link_mode_i`=1) reads one word at the base and returns it on `stack_sel_o`, with `stack_ptr_o`=0. It faults with kind 1 if 4 > limit (32-bit task) or 2 > limit (16-bit task).
- R8: A request that faults issues no memory request at all.
- R9: Every accepted start yields exactly one single-cycle pulse, either on `done_o` or on `fault_o`. The two pulses are never high in the same cycle.
- R10: A start is ignored from the cycle after acceptance until the result pulse. Inputs are captured at acceptance, so later input changes have no effect.
- R11: `mem_req_o` stays high, with `mem_addr_o` and `mem_dword_o` stable, until `mem_ack_i`. `mem_rdata_i` is taken in the acknowledge cycle. The word-read data is in bits 15:0. The pointer is read before the selector.
- R12: After reset, `mem_req_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a lookup (accepted when idle) |
| link_mode_i | input | 1 | 1 = read back-link selector, 0 = stack lookup |
| level_i | input | 2 | Target privilege level |
| desc_type_i | input | 4 | Task register descriptor type |
| seg_base_i | input | 32 | Task segment base address |
| seg_limit_i | input | 32 | Task segment limit |
| task_sel_i | input | 16 | Task register selector |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Read address |
| mem_dword_o | output | 1 | 1 = dword read, 0 = word read |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle success pulse |
| stack_sel_o | output | 16 | Stack selector or back-link selector |
| stack_ptr_o | output | 32 | Stack pointer |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_kind_o | output | 2 | 1 task-segment, 2 bad descriptor, 3 bad level |
| fault_code_o | output | 16 | Fault error code |

## Verification
The assertions check several rules on every cycle:
- the single-cycle, mutually exclusive result pulses;
- the stability of a pending memory request;
- the absence of any request after a failed check;
- the cleared low bits of a task-segment error code;
- the zero upper half of a 16-bit pointer.

The offset arithmetic, the limit boundaries and the fault priority can only be shown by the bench's scenarios, which compare against an independent model under random acknowledge delays. The same holds for the read order, for ignoring a start while busy, and for capturing inputs at acceptance.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;
    localparam int TYPE_W = 4;

    localparam logic [TYPE_W-1:0] TYPE_BUSY32 = 4'hB;
    localparam logic [TYPE_W-1:0] TYPE_BUSY16 = 4'h3;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_TASKSEG = 2'd1,
        FLT_BADDESC = 2'd2,
        FLT_BADLVL  = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RD_SP,
        ST_RD_SEL
    } st_e;

    typedef struct packed {
        logic              link;
        logic [1:0]        lvl;
        logic [TYPE_W-1:0] dtype;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [SEL_W-1:0]  tsel;
    } req_t;

    typedef struct packed {
        flt_e              flt;
        logic              wide;
        logic [ADDR_W-1:0] sp_addr;
        logic [ADDR_W-1:0] sel_addr;
    } plan_t;

    // byte offset of the stack pair for a level
    function automatic logic [ADDR_W-1:0] entry_off(input logic wide, input logic [1:0] lvl);
        if (wide)
            return ADDR_W'({lvl, 3'b100});
        return ADDR_W'({lvl, 2'b10});
    endfunction

    // distance from the first to the last byte of the stack pair
    function automatic logic [ADDR_W-1:0] pair_span(input logic wide);
        return wide ? ADDR_W'(7) : ADDR_W'(3);
    endfunction

    // distance from the pointer to the selector
    function automatic logic [ADDR_W-1:0] sel_step(input logic wide);
        return wide ? ADDR_W'(4) : ADDR_W'(2);
    endfunction

endpackage

// File: rtl/rsf_check.sv
module rsf_check
    import rsf_pkg::*;
(
    input  req_t  req_i,
    output plan_t plan_o
);
    logic              wide;
    logic              narrow;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W:0]   last;
    logic [ADDR_W-1:0] link_need;
    logic [ADDR_W-1:0] sp_addr;

    always_comb begin
        wide      = (req_i.dtype == TYPE_BUSY32);
        narrow    = (req_i.dtype == TYPE_BUSY16);
        off       = entry_off(wide, req_i.lvl);
        last      = {1'b0, off} + {1'b0, pair_span(wide)};
        link_need = sel_step(wide) & {ADDR_W{1'b1}};
        link_need = wide ? ADDR_W'(4) : ADDR_W'(2);
        sp_addr   = req_i.base + off;

        plan_o.wide    = wide;
        plan_o.sp_addr = sp_addr;
        plan_o.sel_addr = req_i.link ? req_i.base : (sp_addr + sel_step(wide));

        if (!wide && !narrow)
            plan_o.flt = FLT_BADDESC;
        else if (req_i.link)
            plan_o.flt = (link_need > req_i.limit) ? FLT_TASKSEG : FLT_NONE;
        else if (req_i.lvl == 2'd3)
            plan_o.flt = FLT_BADLVL;
        else if (last > {1'b0, req_i.limit})
            plan_o.flt = FLT_TASKSEG;
        else
            plan_o.flt = FLT_NONE;
    end

endmodule

// File: rtl/rsf_seq.sv
module rsf_seq
    import rsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  req_t              req_i,
    output req_t              req_q_o,
    input  plan_t             plan_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_dword_o,
    input  logic              mem_ack_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [SEL_W-1:0]  stack_sel_o,
    output logic [ADDR_W-1:0] stack_ptr_o,
    output logic              fault_o,
    output flt_e              fault_kind_o,
    output logic [SEL_W-1:0]  fault_code_o
);
    st_e  state;
    req_t req_q;

    assign req_q_o = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            req_q        <= '0;
            mem_req_o    <= 1'b0;
            mem_addr_o   <= '0;
            mem_dword_o  <= 1'b0;
            done_o       <= 1'b0;
            fault_o      <= 1'b0;
            fault_kind_o <= FLT_NONE;
            fault_code_o <= '0;
            stack_sel_o  <= '0;
            stack_ptr_o  <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        req_q <= req_i;
                        state <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (plan_i.flt != FLT_NONE) begin
                        fault_o      <= 1'b1;
                        fault_kind_o <= plan_i.flt;
                        fault_code_o <= (plan_i.flt == FLT_TASKSEG) ?
                                        {req_q.tsel[SEL_W-1:2], 2'b00} : '0;
                        state        <= ST_IDLE;
                    end else if (req_q.link) begin
                        mem_req_o   <= 1'b1;
                        mem_addr_o  <= plan_i.sel_addr;
                        mem_dword_o <= 1'b0;
                        state       <= ST_RD_SEL;
                    end else begin
                        mem_req_o   <= 1'b1;
                        mem_addr_o  <= plan_i.sp_addr;
                        mem_dword_o <= plan_i.wide;
                        state       <= ST_RD_SP;
                    end
                end
                ST_RD_SP: begin
                    if (mem_ack_i) begin
                        stack_ptr_o <= plan_i.wide ? mem_rdata_i :
                                       {{(ADDR_W-16){1'b0}}, mem_rdata_i[15:0]};
                        mem_addr_o  <= plan_i.sel_addr;
                        mem_dword_o <= 1'b0;
                        state       <= ST_RD_SEL;
                    end
                end
                ST_RD_SEL: begin
                    if (mem_ack_i) begin
                        stack_sel_o <= mem_rdata_i[SEL_W-1:0];
                        if (req_q.link)
                            stack_ptr_o <= '0;
                        mem_req_o <= 1'b0;
                        done_o    <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: result pulses last one cycle and never coincide
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_fault_single_R9: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !fault_o);
    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(done_o && fault_o));

    // R11: a pending request holds address and size until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_dword_o)));

    // R8: a failed check is never followed by a memory request
    assert_no_read_on_fault_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && plan_i.flt != FLT_NONE) |=> !mem_req_o);

    // R3: task-segment fault code is the captured selector with low bits clear
    assert_fault_code_R3: assert property (@(posedge clk) disable iff (rst)
        (fault_o && fault_kind_o == FLT_TASKSEG) |->
        (fault_code_o[1:0] == 2'b00 && fault_code_o[SEL_W-1:2] == req_q.tsel[SEL_W-1:2]));

    // R2: a 16-bit task pointer has a zero upper half
    assert_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !req_q.link && req_q.dtype == TYPE_BUSY16) |-> (stack_ptr_o[ADDR_W-1:16] == '0));

endmodule

// File: rtl/ring_stack_fetch.sv
module ring_stack_fetch
    import rsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              link_mode_i,
    input  logic [1:0]        level_i,
    input  logic [TYPE_W-1:0] desc_type_i,
    input  logic [ADDR_W-1:0] seg_base_i,
    input  logic [ADDR_W-1:0] seg_limit_i,
    input  logic [SEL_W-1:0]  task_sel_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_dword_o,
    input  logic              mem_ack_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [SEL_W-1:0]  stack_sel_o,
    output logic [ADDR_W-1:0] stack_ptr_o,
    output logic              fault_o,
    output logic [1:0]        fault_kind_o,
    output logic [SEL_W-1:0]  fault_code_o
);
    req_t  req_in;
    req_t  req_q;
    plan_t plan;
    flt_e  kind;

    always_comb begin
        req_in.link  = link_mode_i;
        req_in.lvl   = level_i;
        req_in.dtype = desc_type_i;
        req_in.base  = seg_base_i;
        req_in.limit = seg_limit_i;
        req_in.tsel  = task_sel_i;
    end

    rsf_check u_check (
        .req_i  (req_q),
        .plan_o (plan)
    );

    rsf_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .req_i        (req_in),
        .req_q_o      (req_q),
        .plan_i       (plan),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_dword_o  (mem_dword_o),
        .mem_ack_i    (mem_ack_i),
        .mem_rdata_i  (mem_rdata_i),
        .done_o       (done_o),
        .stack_sel_o  (stack_sel_o),
        .stack_ptr_o  (stack_ptr_o),
        .fault_o      (fault_o),
        .fault_kind_o (kind),
        .fault_code_o (fault_code_o)
    );

    assign fault_kind_o = kind;

endmodule

// File: tb/sim_ring_stack_fetch.sv
`timescale 1ns/1ps
module sim_ring_stack_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        link_mode_i = 1'b0;
    logic [1:0]  level_i = 2'd0;
    logic [3:0]  desc_type_i = 4'h0;
    logic [31:0] seg_base_i = '0;
    logic [31:0] seg_limit_i = '0;
    logic [15:0] task_sel_i = '0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_dword_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o;
    logic [15:0] stack_sel_o;
    logic [31:0] stack_ptr_o;
    logic        fault_o;
    logic [1:0]  fault_kind_o;
    logic [15:0] fault_code_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ring_stack_fetch u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .link_mode_i(link_mode_i),
        .level_i(level_i), .desc_type_i(desc_type_i), .seg_base_i(seg_base_i),
        .seg_limit_i(seg_limit_i), .task_sel_i(task_sel_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_dword_o(mem_dword_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .stack_sel_o(stack_sel_o), .stack_ptr_o(stack_ptr_o),
        .fault_o(fault_o), .fault_kind_o(fault_kind_o), .fault_code_o(fault_code_o)
    );

    // memory contents are a pure function of the address
    function automatic logic [31:0] dat(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A_1234;
    endfunction

    // memory responder with random acknowledge delay, driven at negedge
    int          rd_cnt = 0;
    logic [31:0] rd_addr [4];
    logic        rd_dw   [4];
    int          wait_cnt = 0;

    always @(negedge clk) begin
        if (mem_ack_i) begin
            mem_ack_i <= 1'b0;
            wait_cnt  <= $urandom % 3;
        end else if (mem_req_o && !rst) begin
            if (wait_cnt == 0) begin
                logic [31:0] d;
                d = dat(mem_addr_o);
                mem_ack_i   <= 1'b1;
                mem_rdata_i <= mem_dword_o ? d : {~d[31:16], d[15:0]};
                if (rd_cnt < 4) begin
                    rd_addr[rd_cnt] <= mem_addr_o;
                    rd_dw[rd_cnt]   <= mem_dword_o;
                end
                rd_cnt <= rd_cnt + 1;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic link, input logic [1:0] lvl, input logic [3:0] typ,
                       input logic [31:0] base, input logic [31:0] lim,
                       input logic [15:0] tsel, input logic poke);
        logic        wide, narrow;
        int          ek, en, pulses;
        logic [15:0] eerr, esel, g_sel, g_code;
        logic [31:0] ea0, ea1, esp, off, g_sp, d0, d1;
        logic        ed0, g_done, g_fault, got;
        logic [1:0]  g_kind;
        logic [32:0] last;
        string       vtag, ktag;

        wide   = (typ == 4'hB);
        narrow = (typ == 4'h3);
        ek = 0; en = 0; eerr = 0; esel = 0; esp = 0; ea0 = 0; ea1 = 0; ed0 = 0;
        vtag = link ? "R7" : (wide ? "R1" : "R2");
        if (!wide && !narrow) begin
            ek = 2; ktag = "R5";
        end else if (link) begin
            ktag = "R7";
            if ((wide ? 32'd4 : 32'd2) > lim) begin
                ek = 1; eerr = {tsel[15:2], 2'b00};
            end else begin
                en = 1; ea0 = base; ed0 = 1'b0;
                d0 = dat(base); esel = d0[15:0]; esp = 0;
            end
        end else if (lvl == 2'd3) begin
            ek = 3; ktag = "R6";
        end else begin
            ktag = wide ? "R3" : "R4";
            off  = wide ? (32'(lvl) * 8 + 4) : (32'(lvl) * 4 + 2);
            last = {1'b0, off} + (wide ? 33'd7 : 33'd3);
            if (last > {1'b0, lim}) begin
                ek = 1; eerr = {tsel[15:2], 2'b00};
            end else begin
                en = 2; ea0 = base + off; ed0 = wide;
                ea1 = ea0 + (wide ? 32'd4 : 32'd2);
                d0 = dat(ea0); d1 = dat(ea1);
                esp  = wide ? d0 : {16'h0, d0[15:0]};
                esel = d1[15:0];
            end
        end

        @(negedge clk);
        rd_cnt      = 0;
        link_mode_i = link; level_i = lvl; desc_type_i = typ;
        seg_base_i  = base; seg_limit_i = lim; task_sel_i = tsel;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R10: inputs changed after acceptance must not matter
        link_mode_i = ~link; level_i = ~lvl; desc_type_i = typ ^ 4'h8;
        seg_base_i = ~base; seg_limit_i = 32'h0; task_sel_i = ~tsel;

        pulses = 0; got = 0;
        g_done = 0; g_fault = 0; g_kind = 0; g_code = 0; g_sp = 0; g_sel = 0;
        for (int n = 0; n < 80 && !got; n++) begin
            if (poke) start_i = (n == 0);
            @(negedge clk);
            if (done_o || fault_o) begin
                got = 1; pulses++;
                g_done = done_o; g_fault = fault_o; g_kind = fault_kind_o;
                g_code = fault_code_o; g_sp = stack_ptr_o; g_sel = stack_sel_o;
            end
        end
        start_i = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (done_o || fault_o) pulses++;
        end

        check(got, "R9 result pulse seen", 32'(got), 32'd1);
        check(pulses == 1, poke ? "R10 single result while busy" : "R9 single pulse", pulses, 1);
        if (ek != 0) begin
            check(g_fault && !g_done, {ktag, " fault pulse"}, {g_done, g_fault}, 2'b01);
            check(g_kind == 2'(ek), {ktag, " fault kind"}, g_kind, ek);
            check(g_code == eerr, {ktag, " fault code"}, g_code, eerr);
            check(rd_cnt == 0, "R8 no read on fault", rd_cnt, 0);
        end else begin
            check(g_done && !g_fault, {vtag, " done pulse"}, {g_done, g_fault}, 2'b10);
            check(g_sel == esel, {vtag, " selector"}, g_sel, esel);
            check(g_sp == esp, {vtag, " pointer"}, g_sp, esp);
            check(rd_cnt == en, {vtag, " read count"}, rd_cnt, en);
            if (rd_cnt >= 1) begin
                check(rd_addr[0] == ea0, "R11 first read address", rd_addr[0], ea0);
                check(rd_dw[0] == ed0, "R11 first read size", rd_dw[0], ed0);
            end
            if (en == 2 && rd_cnt >= 2) begin
                check(rd_addr[1] == ea1, "R11 second read address", rd_addr[1], ea1);
                check(rd_dw[1] == 1'b0, "R11 second read size", rd_dw[1], 0);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(!mem_req_o, "R12 mem_req after reset", mem_req_o, 0);
        check(!done_o, "R12 done after reset", done_o, 0);
        check(!fault_o, "R12 fault after reset", fault_o, 0);

        // R1 / R3: 32-bit task, exact limit passes, one less faults
        run(0, 2'd0, 4'hB, 32'h0001_0000, 32'd11, 16'h1237, 0);
        run(0, 2'd0, 4'hB, 32'h0001_0000, 32'd10, 16'h1237, 0);
        run(0, 2'd1, 4'hB, 32'h0002_0040, 32'd19, 16'h00AB, 0);
        run(0, 2'd2, 4'hB, 32'h0002_0040, 32'd27, 16'hFFFF, 0);
        run(0, 2'd2, 4'hB, 32'h0002_0040, 32'd26, 16'hFFFF, 0);
        // R2 / R4: 16-bit task boundaries
        run(0, 2'd0, 4'h3, 32'h0000_8000, 32'd5, 16'h0042, 0);
        run(0, 2'd0, 4'h3, 32'h0000_8000, 32'd4, 16'h0042, 0);
        run(0, 2'd2, 4'h3, 32'h0000_8100, 32'd13, 16'h7FF3, 0);
        run(0, 2'd2, 4'h3, 32'h0000_8100, 32'd12, 16'h7FF3, 0);
        // R6: level 3, even with a large limit
        run(0, 2'd3, 4'hB, 32'h0000_1000, 32'hFFFF, 16'h0013, 0);
        // R5: bad descriptor types in both modes
        run(0, 2'd0, 4'h9, 32'h0000_1000, 32'hFFFF, 16'h0013, 0);
        run(1, 2'd3, 4'h1, 32'h0000_1000, 32'hFFFF, 16'h0013, 0);
        // R7: back-link boundaries
        run(1, 2'd1, 4'hB, 32'h0003_0000, 32'd4, 16'h2222, 0);
        run(1, 2'd1, 4'hB, 32'h0003_0000, 32'd3, 16'h2223, 0);
        run(1, 2'd0, 4'h3, 32'h0003_0100, 32'd2, 16'h3331, 0);
        run(1, 2'd0, 4'h3, 32'h0003_0100, 32'd1, 16'h3331, 0);
        // R10: start while busy is ignored
        run(0, 2'd1, 4'hB, 32'h0004_0000, 32'h0000_0067, 16'h0058, 1);
        run(1, 2'd0, 4'h3, 32'h0004_0200, 32'h0000_002B, 16'h0059, 1);
        // address wrap at top of space
        run(0, 2'd2, 4'hB, 32'hFFFF_FFF0, 32'h0000_0067, 16'h0061, 0);

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0]  t;
            logic [1:0]  l;
            logic        lk;
            logic [31:0] lim, need;
            int          sel;
            sel = $urandom % 8;
            t   = (sel < 4) ? 4'hB : (sel < 7) ? 4'h3 : 4'($urandom);
            l   = 2'($urandom);
            lk  = ($urandom % 5) == 0;
            if (lk) need = (t == 4'hB) ? 32'd4 : 32'd2;
            else    need = (t == 4'hB) ? (32'(l) * 8 + 11) : (32'(l) * 4 + 5);
            lim = ($urandom % 6 == 0) ? $urandom : (need + ($urandom % 5) - 2);
            run(lk, l, t, $urandom, lim, 16'($urandom), ($urandom % 4) == 0);
        end

        summary();
        $finish;
    end

endmodule